// File: doc/BRIEF.md
# Super-I/O configuration port controller

This block is the target side of a two-address configuration window. Offset 0 is the index port and offset 1 is the data port. The host first writes a register number to the index port. It then reads or writes the data port to reach that register. At reset the window is closed. The host opens it by writing the open key twice in a row to the index port, and closes it again with a single close key. While the window is closed, the block does not act on any configuration access.

A small set of global registers sits below index 0x30. These registers give the manufacturer and device identity, and they hold the logical-device selector. From index 0x30 upward, the data port reaches the register bank of whichever logical device is selected. The only logical device built here is a general-purpose I/O register file. It has a parameterized number of 8-bit banks. Its direction, output-value and drive-mode registers appear as flat buses for a pad block to use, and its input register reads a flat input bus.

The host interface is a plain synchronous strobe bus. Every strobe is accepted in the cycle it is asserted, so there is no back-pressure. Read data appears on the cycle after the read strobe and stays there until the next read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is closed, the index is 0x00, the logical-device selector is 0x00, `io_rdata` is 0x00, and all GPIO direction, output and mode bits are 0.
- R2: The window opens only when two consecutive index-port writes both carry 0x87. While the window is closed, an index-port write of any other value discards a pending first key.
- R3: While the window is open, an index-port write of 0xAA closes it and leaves the stored index unchanged.
- R4: While the window is closed, every read of either port returns 0xFF. Data-port writes are ignored, and index-port writes other than 0x87 do not change the index.
- R5: The global registers read as follows: index 0x20 gives the high byte of parameter DEV_ID, 0x21 the low byte, 0x22 parameter DEV_REV, 0x23 gives 0x19 and 0x24 gives 0x34. These are read-only. Other global indices below 0x30, except 0x07, read 0x00 and ignore writes.
- R6: Index 0x07 is the read/write logical-device selector. The global registers can be reached whatever value the selector holds.
- R7: When the selector is 0x06, GPIO bank b occupies indices 0xF0−0x10·b to 0xF3−0x10·b, as follows:
  - +0 is direction (1 = output), driving `gpio_oe[8b+7:8b]`.
  - +1 is output value, driving `gpio_do`.
  - +2 is read-only and returns `gpio_in`.
  - +3 is drive mode (1 = push-pull), driving `gpio_pp`.
  - Any other index of 0x30 or above reads 0x00.
- R8: When the selector holds any value other than 0x06, an index of 0x30 or above reads 0x00 and data writes to it are ignored.
- R9: `io_rdata` is updated on the cycle after a read strobe and holds its value otherwise. While the window is open, a read of the index port returns the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 1 | Port select: 0 index, 1 data |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid the cycle after `io_rd` |
| gpio_in | input | NUM_BANKS*8 | Input levels sampled by the bank input registers |
| gpio_oe | output | NUM_BANKS*8 | Direction bits, 1 = output |
| gpio_do | output | NUM_BANKS*8 | Output value bits |
| gpio_pp | output | NUM_BANKS*8 | Drive mode bits, 1 = push-pull, 0 = open drain |

## Verification
The hardest case to reach is an open sequence that was broken partway. The window must stay closed, and because it is closed every read gives 0xFF. So the only way to tell "half open" from "closed" at the ports is what a later key does. The stimulus writes a key, then a different value, then one key, and checks that the data port still reads 0xFF. A further key must then open the window. A second hard case is a write that was dropped because of routing. The bench stores a value in a GPIO register and switches the selector away from 0x06. It then writes that register again, restores the selector, and reads the original value back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_OPEN      = 8'h87;
  localparam logic [7:0] KEY_CLOSE     = 8'hAA;
  localparam logic [7:0] IDX_LDSEL     = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI  = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO  = 8'h21;
  localparam logic [7:0] IDX_REV       = 8'h22;
  localparam logic [7:0] IDX_VEND_HI   = 8'h23;
  localparam logic [7:0] IDX_VEND_LO   = 8'h24;
  localparam logic [7:0] IDX_LD_FIRST  = 8'h30;
  localparam logic [7:0] LD_GPIO       = 8'h06;
  localparam logic [15:0] VENDOR_ID    = 16'h1934;
  localparam logic [7:0] CLOSED_READ   = 8'hFF;

  typedef enum logic [1:0] {
    CFG_CLOSED = 2'd0,
    CFG_HALF   = 2'd1,
    CFG_OPEN   = 2'd2
  } cfg_state_e;
endpackage

// File: rtl/sio_unlock_fsm.sv
module sio_unlock_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       unlocked
);
  cfg_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CFG_CLOSED;
    end else if (idx_wr) begin
      case (state)
        CFG_CLOSED: state <= (wdata == KEY_OPEN) ? CFG_HALF : CFG_CLOSED;
        CFG_HALF:   state <= (wdata == KEY_OPEN) ? CFG_OPEN : CFG_CLOSED;
        CFG_OPEN:   if (wdata == KEY_CLOSE) state <= CFG_CLOSED;
        default:    state <= CFG_CLOSED;
      endcase
    end
  end

  assign unlocked = (state == CFG_OPEN);
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h1010,
  parameter logic [7:0]  DEV_REV = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlocked,
  input  logic       idx_wr,
  input  logic       dat_wr,
  input  logic [7:0] wdata,
  output logic [7:0] index,
  output logic [7:0] ldsel,
  output logic [7:0] glb_rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index <= 8'h00;
      ldsel <= 8'h00;
    end else begin
      if (unlocked && idx_wr && wdata != KEY_CLOSE) index <= wdata;
      if (unlocked && dat_wr && index == IDX_LDSEL) ldsel <= wdata;
    end
  end

  always_comb begin
    case (index)
      IDX_LDSEL:    glb_rdata = ldsel;
      IDX_DEVID_HI: glb_rdata = DEV_ID[15:8];
      IDX_DEVID_LO: glb_rdata = DEV_ID[7:0];
      IDX_REV:      glb_rdata = DEV_REV;
      IDX_VEND_HI:  glb_rdata = VENDOR_ID[15:8];
      IDX_VEND_LO:  glb_rdata = VENDOR_ID[7:0];
      default:      glb_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sio_gpio_ld.sv
module sio_gpio_ld #(
  parameter int          NUM_BANKS   = 4,
  parameter logic [7:0]  BASE_TOP    = 8'hF0,
  parameter logic [7:0]  BANK_STRIDE = 8'h10,
  localparam int         GPIO_W      = NUM_BANKS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        index,
  input  logic [7:0]        wdata,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [7:0]        rdata,
  output logic [GPIO_W-1:0] gpio_oe,
  output logic [GPIO_W-1:0] gpio_do,
  output logic [GPIO_W-1:0] gpio_pp
);
  logic [7:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [7:0] BASE = BASE_TOP - BANK_STRIDE * b;
    logic [7:0] dir_q, out_q, mode_q;
    logic       hit_dir, hit_out, hit_in, hit_mode;

    assign hit_dir  = (index == BASE);
    assign hit_out  = (index == BASE + 8'd1);
    assign hit_in   = (index == BASE + 8'd2);
    assign hit_mode = (index == BASE + 8'd3);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dir_q  <= 8'h00;
        out_q  <= 8'h00;
        mode_q <= 8'h00;
      end else if (wr_en) begin
        if (hit_dir)  dir_q  <= wdata;
        if (hit_out)  out_q  <= wdata;
        if (hit_mode) mode_q <= wdata;
      end
    end

    always_comb begin
      bank_rd[b] = 8'h00;
      if (hit_dir)  bank_rd[b] = dir_q;
      if (hit_out)  bank_rd[b] = out_q;
      if (hit_in)   bank_rd[b] = gpio_in[8*b +: 8];
      if (hit_mode) bank_rd[b] = mode_q;
    end

    assign gpio_oe[8*b +: 8] = dir_q;
    assign gpio_do[8*b +: 8] = out_q;
    assign gpio_pp[8*b +: 8] = mode_q;
  end

  always_comb begin
    rdata = 8'h00;
    for (int b = 0; b < NUM_BANKS; b++) rdata = rdata | bank_rd[b];
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID    = 16'h1010,
  parameter logic [7:0]  DEV_REV   = 8'h11,
  parameter int          NUM_BANKS = 4,
  localparam int         GPIO_W    = NUM_BANKS * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] gpio_oe,
  output logic [GPIO_W-1:0] gpio_do,
  output logic [GPIO_W-1:0] gpio_pp
);
  logic       idx_wr, dat_wr, unlocked, ld_space, gpio_wr;
  logic [7:0] cfg_index, ldsel, glb_rdata, gpio_rdata, rd_next;

  assign idx_wr = io_wr && !io_addr;
  assign dat_wr = io_wr && io_addr;

  sio_unlock_fsm u_lock (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .wdata(io_wdata),
    .unlocked(unlocked)
  );

  sio_global_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glb (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wdata(io_wdata), .index(cfg_index), .ldsel(ldsel),
    .glb_rdata(glb_rdata)
  );

  assign ld_space = (cfg_index >= IDX_LD_FIRST);
  assign gpio_wr  = unlocked && dat_wr && ld_space && (ldsel == LD_GPIO);

  sio_gpio_ld #(.NUM_BANKS(NUM_BANKS)) u_gpio (
    .clk(clk), .rst_n(rst_n), .wr_en(gpio_wr), .index(cfg_index),
    .wdata(io_wdata), .gpio_in(gpio_in), .rdata(gpio_rdata),
    .gpio_oe(gpio_oe), .gpio_do(gpio_do), .gpio_pp(gpio_pp)
  );

  always_comb begin
    if (!unlocked)              rd_next = CLOSED_READ;
    else if (!io_addr)          rd_next = cfg_index;
    else if (!ld_space)         rd_next = glb_rdata;
    else if (ldsel == LD_GPIO)  rd_next = gpio_rdata;
    else                        rd_next = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     io_rdata <= 8'h00;
    else if (io_rd) io_rdata <= rd_next;
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int GPIO_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              unlocked,
  input logic [7:0]        cfg_index,
  input logic [GPIO_W-1:0] gpio_oe,
  input logic [GPIO_W-1:0] gpio_do,
  input logic [GPIO_W-1:0] gpio_pp
);
  // R2
  no_open_without_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_wr && !io_addr && io_wdata != 8'h87) |=> !unlocked);

  // R3
  close_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && !io_addr && io_wdata == 8'hAA) |=> !unlocked);

  // R4
  closed_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !unlocked) |=> io_rdata == 8'hFF);

  // R4
  closed_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr && !unlocked) |=>
      ($stable(gpio_oe) && $stable(gpio_do) && $stable(gpio_pp)));

  // R5
  vendor_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_rd && io_addr && cfg_index == 8'h23) |=> io_rdata == 8'h19);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .unlocked(unlocked),
  .cfg_index(cfg_index), .gpio_oe(gpio_oe), .gpio_do(gpio_do),
  .gpio_pp(gpio_pp)
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
  localparam int NB = 4;
  localparam int GW = NB * 8;
  localparam logic [GW-1:0] PIN_IN = 32'hA55A_3CC3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          io_addr = 1'b0;
  logic [7:0]    io_wdata = 8'h00;
  logic          io_wr = 1'b0;
  logic          io_rd = 1'b0;
  logic [7:0]    io_rdata;
  logic [GW-1:0] gpio_in = PIN_IN;
  logic [GW-1:0] gpio_oe, gpio_do, gpio_pp;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_port #(.DEV_ID(16'h1010), .DEV_REV(8'h11), .NUM_BANKS(NB)) u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .gpio_in(gpio_in),
    .gpio_oe(gpio_oe), .gpio_do(gpio_do), .gpio_pp(gpio_pp)
  );

  // vector: {req[3:0], is_read, port, data, expected}
  function automatic logic [21:0] v(logic [3:0] r, logic rd, logic a,
                                    logic [7:0] d, logic [7:0] e);
    return {r, rd, a, d, e};
  endfunction

  localparam int NV = 59;
  localparam logic [21:0] VEC [NV] = '{
    v(4, 1, 1, 0, 8'hFF),     // R4 closed data read
    v(4, 1, 0, 0, 8'hFF),     // R4 closed index read
    v(0, 0, 0, 8'h87, 0),     // R2 first key
    v(0, 0, 0, 8'h12, 0),     // R2 break
    v(0, 0, 0, 8'h87, 0),
    v(2, 1, 1, 0, 8'hFF),     // R2 still closed
    v(0, 0, 0, 8'h87, 0),     // opens
    v(9, 1, 0, 0, 8'h00),     // R9 index read
    v(0, 0, 0, 8'h20, 0),
    v(5, 1, 1, 0, 8'h10),     // R5
    v(0, 0, 0, 8'h21, 0),
    v(5, 1, 1, 0, 8'h10),
    v(0, 0, 0, 8'h22, 0),
    v(5, 1, 1, 0, 8'h11),
    v(0, 0, 0, 8'h23, 0),
    v(5, 1, 1, 0, 8'h19),
    v(0, 0, 0, 8'h24, 0),
    v(5, 1, 1, 0, 8'h34),
    v(0, 0, 0, 8'h25, 0),
    v(5, 1, 1, 0, 8'h00),
    v(0, 0, 1, 8'h5A, 0),
    v(5, 1, 1, 0, 8'h00),     // R5 write ignored
    v(0, 0, 0, 8'h07, 0),
    v(6, 1, 1, 0, 8'h00),     // R6
    v(0, 0, 1, 8'h06, 0),
    v(6, 1, 1, 0, 8'h06),
    v(0, 0, 0, 8'hF0, 0),
    v(0, 0, 1, 8'hFF, 0),
    v(7, 1, 1, 0, 8'hFF),     // R7 bank0 dir
    v(0, 0, 0, 8'hE1, 0),
    v(0, 0, 1, 8'h3C, 0),
    v(7, 1, 1, 0, 8'h3C),     // R7 bank1 out
    v(0, 0, 0, 8'hD2, 0),
    v(7, 1, 1, 0, 8'h5A),     // R7 bank2 input
    v(0, 0, 1, 8'h00, 0),
    v(7, 1, 1, 0, 8'h5A),     // R7 input read-only
    v(0, 0, 0, 8'hC3, 0),
    v(0, 0, 1, 8'h81, 0),
    v(7, 1, 1, 0, 8'h81),     // R7 bank3 mode
    v(0, 0, 0, 8'hF4, 0),
    v(7, 1, 1, 0, 8'h00),     // R7 unmapped
    v(0, 0, 0, 8'h20, 0),
    v(6, 1, 1, 0, 8'h10),     // R6 global with GPIO selected
    v(0, 0, 0, 8'h07, 0),
    v(0, 0, 1, 8'h03, 0),
    v(0, 0, 0, 8'hF0, 0),
    v(8, 1, 1, 0, 8'h00),     // R8
    v(0, 0, 1, 8'h00, 0),
    v(0, 0, 0, 8'h07, 0),
    v(0, 0, 1, 8'h06, 0),
    v(0, 0, 0, 8'hF0, 0),
    v(8, 1, 1, 0, 8'hFF),     // R8 write was ignored
    v(0, 0, 0, 8'hAA, 0),
    v(3, 1, 1, 0, 8'hFF),     // R3 closed
    v(0, 0, 1, 8'h00, 0),
    v(0, 0, 0, 8'h87, 0),
    v(0, 0, 0, 8'h87, 0),
    v(9, 1, 0, 0, 8'hF0),     // R9 R3 index kept
    v(4, 1, 1, 0, 8'hFF)      // R4 closed write ignored
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(logic a, logic rd, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wr = !rd; io_rd = rd; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdata", {24'h0, io_rdata}, 32'h0);
    chk("R1 oe", gpio_oe, 32'h0);
    chk("R1 do_pp", gpio_do | gpio_pp, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] e;
      e = VEC[i];
      access(e[16], e[17], e[15:8]);
      if (e[17]) chk($sformatf("R%0d vec%0d", e[21:18], i), {24'h0, io_rdata}, {24'h0, e[7:0]});
    end

    chk("R7 oe", gpio_oe, 32'h0000_00FF);
    chk("R7 do", gpio_do, 32'h0000_3C00);
    chk("R7 pp", gpio_pp, 32'h8100_0000);

    // R9 hold: open, read index, idle, check unchanged
    access(0, 0, 8'h87);
    access(0, 0, 8'h87);
    access(0, 0, 8'h22);
    access(0, 1, 8'h00);
    repeat (4) @(negedge clk);
    chk("R9 hold", {24'h0, io_rdata}, 32'h22);

    // R1 mid-run reset
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rst rdata", {24'h0, io_rdata}, 32'h0);
    chk("R1 rst oe", gpio_oe, 32'h0);
    access(1, 1, 8'h00);
    chk("R1 rst closed", {24'h0, io_rdata}, 32'hFF);
    access(0, 0, 8'h87);
    access(0, 0, 8'h87);
    access(0, 1, 8'h00);
    chk("R1 rst index", {24'h0, io_rdata}, 32'h00);
    access(0, 0, 8'h07);
    access(1, 1, 8'h00);
    chk("R1 rst ldsel", {24'h0, io_rdata}, 32'h00);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule